// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks load-linked reservations on cache lines for the requesters that share one cache port. Every completed write-class operation is presented with its line address, an operation code and a requester ID. A load-linked places a reservation on its line, tagged with the requester. A later store-conditional from the same requester on the same line succeeds only while that reservation survives. Store-conditionals, the requester's own ordinary writes, and a loss of coherence permission on a line whose store-conditional is still pending all remove reservations.

The reservation store is a small table of line addresses, each with an owner ID, a valid bit and an age. A load-linked to a new line takes the lowest free slot, or replaces the oldest slot when the table is full. The block also keeps one block/unblock flag for locked read-modify-write sequences, so that the controller can hold off the line between the locked read and the locked write. A bypass input turns reservation handling off, and every operation then reports success.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 1) always gets result 1 and leaves a reservation on its line owned by op_id_i.
- R2: A store-conditional (op code 2) gets result 1 only when its line holds a valid reservation whose owner equals op_id_i. Otherwise it gets result 0.
- R3: Every store-conditional removes the reservation on its line, whatever the outcome and whoever owns it.
- R4: Every other op code (0 store, 3 locked read, 4 locked write, 5 read-modify-write, and the unused codes 6 and 7) gets result 1. It removes the reservation on its line only when the owner equals op_id_i. A reservation held by another requester stays.
- R5: When loss_valid_i and loss_sc_pend_i are both high, the reservation on loss_line_i is removed, whoever owns it. With loss_sc_pend_i low, nothing changes. A load-linked to the same line in the same cycle wins and keeps its reservation.
- R6: A locked read (code 3) sets block_o and loads block_line_o with its line. A locked write (code 4) to the blocked line clears block_o. A locked write to any other line leaves block_o unchanged. Bypass does not affect this.
- R7: While bypass_i is high, operations change no reservation and every result is 1. The loss input keeps its effect.
- R8: A load-linked to a line that already holds a reservation moves the ownership to op_id_i and uses no new slot. A load-linked to a new line takes the lowest free slot. When all NUM_ENTRIES slots are full, it replaces the slot that was allocated longest ago.
- R9: res_valid_o pulses high for exactly the one cycle after each op_valid_i. res_ok_o is low whenever res_valid_o is low. Table updates are seen by an operation in the next cycle. After reset all outputs are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Skip reservation handling, report success |
| op_valid_i | input | 1 | A completed operation is presented |
| op_type_i | input | 3 | Operation code |
| op_line_i | input | LINE_W | Line address of the operation |
| op_id_i | input | ID_W | Requester ID |
| loss_valid_i | input | 1 | Coherence permission lost on loss_line_i |
| loss_sc_pend_i | input | 1 | A store-conditional is pending on the lost line |
| loss_line_i | input | LINE_W | Line that lost permission |
| res_valid_o | output | 1 | Result strobe, one cycle after the operation |
| res_ok_o | output | 1 | Result: 1 success, 0 store-conditional failure |
| block_o | output | 1 | Line held for a locked read-modify-write |
| block_line_o | output | LINE_W | Line being held |

## Verification
Each operation's result appears on res_valid_o and res_ok_o at the first rising edge after the edge that samples it. block_o and block_line_o change at that same edge. A change to the table shows up only in the result of an operation sampled at a later edge. The bench drives each operation on a falling edge and compares all outputs at the next falling edge against a reference model of the table that it advances once per cycle. Back-to-back operations therefore test that every update is visible exactly one cycle later. The directed cases cover the ownership, eviction, permission-loss and bypass boundaries.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  localparam logic [2:0] OP_STORE   = 3'd0;
  localparam logic [2:0] OP_LL      = 3'd1;
  localparam logic [2:0] OP_SC      = 3'd2;
  localparam logic [2:0] OP_LOCK_RD = 3'd3;
  localparam logic [2:0] OP_LOCK_WR = 3'd4;
  localparam logic [2:0] OP_RMW     = 3'd5;
endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 26
) (
  input  logic [NUM_ENTRIES-1:0]             valid_i,
  input  logic [NUM_ENTRIES-1:0][LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0]                  key_i,
  output logic [NUM_ENTRIES-1:0]             hit_o
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign hit_o[g] = valid_i[g] && (lines_i[g] == key_i);
  end
endmodule

// File: rtl/llsc_age.sv
module llsc_age #(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_ENTRIES-1:0] valid_i,
  input  logic [NUM_ENTRIES-1:0] inv_i,
  input  logic                   alloc_i,
  input  logic [IDX_W-1:0]       alloc_idx_i,
  output logic [IDX_W-1:0]       victim_idx_o
);
  localparam int AGE_W = IDX_W;

  logic [NUM_ENTRIES-1:0][AGE_W-1:0] age_q, age_d;

  // lowest free slot, else the slot with the highest age
  always_comb begin
    logic found;
    found        = 1'b0;
    victim_idx_o = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        victim_idx_o = IDX_W'(i);
        found        = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (age_q[i] == AGE_W'(NUM_ENTRIES - 1)) victim_idx_o = IDX_W'(i);
      end
    end
  end

  // ages of live slots stay a dense 0..k-1 ranking
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      logic [AGE_W-1:0] drop;
      drop = '0;
      for (int j = 0; j < NUM_ENTRIES; j++) begin
        if (inv_i[j] && valid_i[j] && (age_q[j] < age_q[i])) drop = drop + 1'b1;
      end
      if (alloc_i && (alloc_idx_i == IDX_W'(i)))
        age_d[i] = '0;
      else if (valid_i[i] && !inv_i[i])
        age_d[i] = age_q[i] - drop + AGE_W'(alloc_i);
      else
        age_d[i] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int LINE_W      = 26,
  parameter int ID_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bypass_i,
  input  logic              op_valid_i,
  input  logic [2:0]        op_type_i,
  input  logic [LINE_W-1:0] op_line_i,
  input  logic [ID_W-1:0]   op_id_i,
  input  logic              loss_valid_i,
  input  logic              loss_sc_pend_i,
  input  logic [LINE_W-1:0] loss_line_i,
  output logic              res_valid_o,
  output logic              res_ok_o,
  output logic              block_o,
  output logic [LINE_W-1:0] block_line_o
);
  localparam int IDX_W = (NUM_ENTRIES > 2) ? $clog2(NUM_ENTRIES) : 1;

  logic [NUM_ENTRIES-1:0]             vld_q, vld_d;
  logic [NUM_ENTRIES-1:0][LINE_W-1:0] line_q, line_d;
  logic [NUM_ENTRIES-1:0][ID_W-1:0]   own_q, own_d;

  logic [NUM_ENTRIES-1:0] op_hit, loss_hit, id_eq, own_hit;
  logic [NUM_ENTRIES-1:0] inv_mask;
  logic [IDX_W-1:0]       victim_idx, hit_idx;
  logic                   is_ll, is_sc, is_wr, alloc, sc_ok;
  logic                   res_valid_q, res_ok_q, blk_q;
  logic [LINE_W-1:0]      blk_line_q;

  llsc_match #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W)) i_op_match (
    .valid_i (vld_q),
    .lines_i (line_q),
    .key_i   (op_line_i),
    .hit_o   (op_hit)
  );

  llsc_match #(.NUM_ENTRIES(NUM_ENTRIES), .LINE_W(LINE_W)) i_loss_match (
    .valid_i (vld_q),
    .lines_i (line_q),
    .key_i   (loss_line_i),
    .hit_o   (loss_hit)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_owner
    assign id_eq[g] = (own_q[g] == op_id_i);
  end
  assign own_hit = op_hit & id_eq;

  llsc_age #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) i_age (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (vld_q),
    .inv_i        (inv_mask),
    .alloc_i      (alloc),
    .alloc_idx_i  (victim_idx),
    .victim_idx_o (victim_idx)
  );

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (op_hit[i]) hit_idx = IDX_W'(i);
    end
  end

  assign is_ll = op_valid_i && !bypass_i && (op_type_i == OP_LL);
  assign is_sc = op_valid_i && !bypass_i && (op_type_i == OP_SC);
  assign is_wr = op_valid_i && !bypass_i && !(op_type_i == OP_LL) && !(op_type_i == OP_SC);
  assign sc_ok = |own_hit;
  assign alloc = is_ll && !(|op_hit);

  always_comb begin
    inv_mask = '0;
    if (loss_valid_i && loss_sc_pend_i)
      inv_mask = loss_hit & ~(is_ll ? op_hit : '0);  // same-cycle LL wins
    if (is_sc) inv_mask = inv_mask | op_hit;
    if (is_wr) inv_mask = inv_mask | own_hit;
  end

  always_comb begin
    vld_d  = vld_q & ~inv_mask;
    line_d = line_q;
    own_d  = own_q;
    if (alloc) begin
      vld_d[victim_idx]  = 1'b1;
      line_d[victim_idx] = op_line_i;
      own_d[victim_idx]  = op_id_i;
    end else if (is_ll) begin
      own_d[hit_idx] = op_id_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      line_q <= '0;
      own_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      line_q <= line_d;
      own_q  <= own_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q <= 1'b0;
      res_ok_q    <= 1'b0;
    end else begin
      res_valid_q <= op_valid_i;
      res_ok_q    <= op_valid_i && !(is_sc && !sc_ok);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q      <= 1'b0;
      blk_line_q <= '0;
    end else if (op_valid_i && (op_type_i == OP_LOCK_RD)) begin
      blk_q      <= 1'b1;
      blk_line_q <= op_line_i;
    end else if (op_valid_i && (op_type_i == OP_LOCK_WR) && blk_q && (blk_line_q == op_line_i)) begin
      blk_q      <= 1'b0;
    end
  end

  assign res_valid_o  = res_valid_q;
  assign res_ok_o     = res_ok_q;
  assign block_o      = blk_q;
  assign block_line_o = blk_line_q;
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_i,
  input logic              op_valid_i,
  input logic [2:0]        op_type_i,
  input logic [LINE_W-1:0] op_line_i,
  input logic [ID_W-1:0]   op_id_i,
  input logic              res_valid_o,
  input logic              res_ok_o,
  input logic              block_o,
  input logic [LINE_W-1:0] block_line_o
);
  a_r9_result_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> res_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> !res_valid_o);
  a_r9_ok_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_ok_o |-> res_valid_o);
  a_r1_ll_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_type_i == 3'd1) |=> res_ok_o);
  a_r4_write_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_type_i != 3'd2) |=> res_ok_o);
  a_r7_bypass_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && bypass_i) |=> res_ok_o);
  a_r6_block_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_type_i == 3'd3) |=> (block_o && block_line_o == $past(op_line_i)));
  a_r3_sc_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_type_i == 3'd2 && !bypass_i &&
     $past(op_valid_i && op_type_i == 3'd2 && !bypass_i) &&
     op_line_i == $past(op_line_i) && op_id_i == $past(op_id_i)) |=> !res_ok_o);
endmodule

bind llsc_monitor llsc_monitor_chk #(.LINE_W(LINE_W), .ID_W(ID_W)) i_llsc_monitor_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bypass_i     (bypass_i),
  .op_valid_i   (op_valid_i),
  .op_type_i    (op_type_i),
  .op_line_i    (op_line_i),
  .op_id_i      (op_id_i),
  .res_valid_o  (res_valid_o),
  .res_ok_o     (res_ok_o),
  .block_o      (block_o),
  .block_line_o (block_line_o)
);

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
  localparam int N      = 4;
  localparam int LINE_W = 26;
  localparam int ID_W   = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bypass_i = 1'b0;
  logic              op_valid_i = 1'b0;
  logic [2:0]        op_type_i = '0;
  logic [LINE_W-1:0] op_line_i = '0;
  logic [ID_W-1:0]   op_id_i = '0;
  logic              loss_valid_i = 1'b0;
  logic              loss_sc_pend_i = 1'b0;
  logic [LINE_W-1:0] loss_line_i = '0;
  logic              res_valid_o, res_ok_o, block_o;
  logic [LINE_W-1:0] block_line_o;

  always #10 clk_i = ~clk_i;

  llsc_monitor #(.NUM_ENTRIES(N), .LINE_W(LINE_W), .ID_W(ID_W)) i_llsc_monitor (.*);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference table
  bit              m_v[N];
  logic [LINE_W-1:0] m_l[N];
  logic [ID_W-1:0]   m_o[N];
  int              m_a[N];
  bit              m_blk;
  logic [LINE_W-1:0] m_bl;
  bit              e_rv, e_ok;

  function automatic bit sc_result(logic [LINE_W-1:0] l, logic [ID_W-1:0] id);
    for (int i = 0; i < N; i++) if (m_v[i] && m_l[i] == l && m_o[i] == id) return 1;
    return 0;
  endfunction

  task automatic model(bit v, logic [2:0] t, logic [LINE_W-1:0] l, logic [ID_W-1:0] id,
                       bit byp, bit lv, bit lp, logic [LINE_W-1:0] ll);
    bit is_ll, is_sc, is_wr, alloc;
    bit inv[N];
    int hit, vic, drop;
    int na[N];
    is_ll = v && !byp && t == 3'd1;
    is_sc = v && !byp && t == 3'd2;
    is_wr = v && !byp && t != 3'd1 && t != 3'd2;
    hit = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_l[i] == l) hit = i;
    e_rv = v;
    e_ok = v && !(is_sc && !sc_result(l, id));
    for (int i = 0; i < N; i++) begin
      inv[i] = 0;
      if (lv && lp && m_v[i] && m_l[i] == ll && !(is_ll && i == hit)) inv[i] = 1;
    end
    if (is_sc && hit >= 0) inv[hit] = 1;
    if (is_wr && hit >= 0 && m_o[hit] == id) inv[hit] = 1;
    alloc = is_ll && hit < 0;
    vic = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) vic = i;
    if (vic < 0) for (int i = 0; i < N; i++) if (m_a[i] == N - 1) vic = i;
    for (int i = 0; i < N; i++) begin
      drop = 0;
      for (int j = 0; j < N; j++) if (inv[j] && m_v[j] && m_a[j] < m_a[i]) drop++;
      if (alloc && i == vic) na[i] = 0;
      else if (m_v[i] && !inv[i]) na[i] = m_a[i] - drop + (alloc ? 1 : 0);
      else na[i] = 0;
    end
    for (int i = 0; i < N; i++) begin
      m_a[i] = na[i];
      if (inv[i]) m_v[i] = 0;
    end
    if (alloc) begin
      m_v[vic] = 1; m_l[vic] = l; m_o[vic] = id;
    end else if (is_ll) m_o[hit] = id;
    if (v && t == 3'd3) begin m_blk = 1; m_bl = l; end
    else if (v && t == 3'd4 && m_blk && m_bl == l) m_blk = 0;
  endtask

  task automatic check(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // inputs at a falling edge, outputs compared at the next falling edge
  task automatic step(string tag, bit v, logic [2:0] t, logic [LINE_W-1:0] l,
                      logic [ID_W-1:0] id, bit byp = 0, bit lv = 0, bit lp = 0,
                      logic [LINE_W-1:0] ll = '0);
    op_valid_i = v; op_type_i = t; op_line_i = l; op_id_i = id; bypass_i = byp;
    loss_valid_i = lv; loss_sc_pend_i = lp; loss_line_i = ll;
    model(v, t, l, id, byp, lv, lp, ll);
    @(negedge clk_i);
    check({tag, " res_valid"}, res_valid_o, e_rv);
    check({tag, " res_ok"}, res_ok_o, e_ok);
    check({tag, " block"}, block_o, m_blk);
    if (m_blk) begin
      n_run++;
      if (block_line_o !== m_bl) begin
        n_fail++;
        $display("FAIL %s block_line: got %0h expected %0h", tag, block_line_o, m_bl);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_l[i] = '0; m_o[i] = '0; m_a[i] = 0; end
    m_blk = 0; m_bl = '0;
    repeat (3) @(negedge clk_i);
    check("R9 reset res_valid", res_valid_o, 1'b0);
    check("R9 reset res_ok", res_ok_o, 1'b0);
    check("R9 reset block", block_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 / R2 / R3
    step("R1 ll", 1, 3'd1, 26'h10, 4'd1);
    step("R2 sc own", 1, 3'd2, 26'h10, 4'd1);
    step("R3 sc again", 1, 3'd2, 26'h10, 4'd1);
    step("R1 ll id2", 1, 3'd1, 26'h11, 4'd2);
    step("R3 sc other id", 1, 3'd2, 26'h11, 4'd3);
    step("R3 sc after foreign", 1, 3'd2, 26'h11, 4'd2);
    // R4
    step("R1 ll", 1, 3'd1, 26'h12, 4'd1);
    step("R4 store other id", 1, 3'd0, 26'h12, 4'd2);
    step("R4 sc kept", 1, 3'd2, 26'h12, 4'd1);
    step("R1 ll", 1, 3'd1, 26'h12, 4'd1);
    step("R4 rmw own", 1, 3'd5, 26'h12, 4'd1);
    step("R4 sc cleared", 1, 3'd2, 26'h12, 4'd1);
    // R5
    step("R1 ll", 1, 3'd1, 26'h13, 4'd1);
    step("R5 loss no pend", 0, 3'd0, 26'h0, 4'd0, 0, 1, 0, 26'h13);
    step("R5 sc kept", 1, 3'd2, 26'h13, 4'd1);
    step("R1 ll", 1, 3'd1, 26'h13, 4'd1);
    step("R5 loss pend", 0, 3'd0, 26'h0, 4'd0, 0, 1, 1, 26'h13);
    step("R5 sc cleared", 1, 3'd2, 26'h13, 4'd1);
    step("R5 ll wins", 1, 3'd1, 26'h14, 4'd2, 0, 1, 1, 26'h14);
    step("R5 sc after ll win", 1, 3'd2, 26'h14, 4'd2);
    // R6
    step("R6 lock rd", 1, 3'd3, 26'h20, 4'd1);
    step("R6 lock wr other", 1, 3'd4, 26'h21, 4'd1);
    step("R6 lock wr same", 1, 3'd4, 26'h20, 4'd1, 1);
    // R7
    step("R7 bypass sc", 1, 3'd2, 26'h30, 4'd1, 1);
    step("R7 bypass ll", 1, 3'd1, 26'h30, 4'd1, 1);
    step("R7 sc no resv", 1, 3'd2, 26'h30, 4'd1);
    // R8
    step("R8 ll owner move", 1, 3'd1, 26'h40, 4'd1);
    step("R8 ll owner move", 1, 3'd1, 26'h40, 4'd2);
    step("R8 sc old owner", 1, 3'd2, 26'h40, 4'd1);
    for (int k = 0; k < 5; k++) step("R8 fill", 1, 3'd1, 26'h50 + k, 4'd3);
    step("R8 oldest evicted", 1, 3'd2, 26'h50, 4'd3);
    step("R8 next kept", 1, 3'd2, 26'h51, 4'd3);
    // R9 idle
    step("R9 idle", 0, 3'd2, 26'h52, 4'd3);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      bit v, byp, lv, lp;
      logic [2:0] t;
      int r;
      v   = ($urandom % 10) < 7;
      r   = $urandom % 8;
      t   = (r < 3) ? 3'd1 : (r < 6) ? 3'd2 : 3'($urandom % 8);
      byp = ($urandom % 10) == 0;
      lv  = ($urandom % 7) == 0;
      lp  = $urandom % 2;
      step("R9 random", v, t, LINE_W'($urandom % 7), ID_W'($urandom % 3), byp, lv, lp,
           LINE_W'($urandom % 7));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule